// File: doc/BRIEF.md
# Double-Hash Nonce Search Engine

This block searches for a proof-of-work nonce. It takes an 80-byte block header, captures it when `start` is pulsed and then tries candidate nonces one after another. For each candidate it writes the nonce into the header and computes SHA-256 of the result. It then computes SHA-256 of that 32-byte digest. The final digest is compared with a 256-bit target. The target is not supplied from outside: the block expands it from the compact difficulty word carried inside the header.

Two iterative SHA-256 round engines form a two-stage pipeline. The first engine hashes the header for nonce k and hands its digest to the second engine. In the same cycle it starts on nonce k+1. The first 64 header bytes do not change between candidates, so their compression result (the midstate) is computed once per search and reused for every nonce. When a candidate succeeds, the engine latches that nonce and stops. When every candidate fails, it reports that it is done without a result. A `clr` pulse abandons the search and empties both stages.

Top module: `nonce_search`

## Requirements
- R1: After reset `found` and `done` are low and `nonce` reads zero. `nonce` reads zero at any time that `found` is low.
- R2: For candidate n, the block hashes the captured header with n written little-endian into bytes 76..79, using SHA-256. It then hashes the 32-byte digest of that first pass with SHA-256 again. Header byte 0 occupies `header[639:632]`, and byte j occupies `header[639-8j -: 8]`.
- R3: The compact word is header bytes 72..75 read little-endian. Its top byte is the exponent E and its low 24 bits are the mantissa M. The target is M shifted left by 8*(E-3) bits when E >= 3, and M shifted right by 8*(3-E) bits otherwise. Bits shifted beyond 256 are lost.
- R4: A candidate succeeds only when the final digest, read as a little-endian 256-bit integer (digest byte 31 most significant), is strictly below the target.
- R5: Candidates are tried in order from zero, one step at a time, so the reported nonce is the lowest one that succeeds.
- R6: On success `found` and `done` go high and `nonce` holds the winning value. All three stay unchanged until `start` or `clr`. A `start` pulse drops `found` and `done` in the next cycle.
- R7: If every value from 0 to 2^NONCE_BITS-1 fails, `done` goes high with `found` low.
- R8: `clr` takes priority over `start` and flushes both stages. `done` and `found` are low in the next cycle, and no result appears until a new `start`.
- R9: The midstate takes 65 cycles. After that, one candidate leaves the first stage every 65 cycles. The outcome for candidate k appears 195+65k clock edges after the edge that samples `start`. The second stage is always free when the first stage hands over.
- R10: The header is captured at `start`. Later changes on `header` have no effect on the running search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Abandon search and flush both stages |
| start | input | 1 | Capture header and begin search at nonce zero |
| header | input | 640 | 80-byte header; the nonce field is overwritten by the engine |
| found | output | 1 | A nonce meeting the target was found |
| done | output | 1 | Search finished, with or without success |
| nonce | output | 32 | Winning nonce, zero unless `found` |

## Verification
The assertions assume that `start` and `clr` are single-cycle synchronous pulses. They also assume that no result is expected across a `start`, because a new start restarts the midstate and clears the previous outcome. The stimulus keeps `header` free to change at any time, relying on R10. It raises `start` and `clr` only for one cycle between falling edges. The nonce space is shrunk to six bits through `NONCE_BITS`, so that the exhaustion path and its exact cycle count are reached. Success probabilities are set through the compact word, so that the stimulus covers first-candidate hits, hits further along and searches that never hit.

// File: rtl/ns_pkg.sv
package ns_pkg;
  localparam int WORD  = 32;
  localparam int DIG_W = 256;
  localparam int BLK_W = 512;
  localparam int HDR_W = 640;
  localparam int TAIL_W = 96;

  typedef enum logic [1:0] {S_IDLE, S_MID, S_SRCH, S_FIN} ns_state_e;

  localparam logic [DIG_W-1:0] SHA_IV = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  localparam logic [64*WORD-1:0] SHA_K = {
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  function automatic logic [WORD-1:0] round_k(input logic [5:0] i);
    return SHA_K[64*WORD-1 - WORD*int'(i) -: WORD];
  endfunction

  function automatic logic [WORD-1:0] rotr(input logic [WORD-1:0] x, input int n);
    return (x >> n) | (x << (WORD - n));
  endfunction

  function automatic logic [WORD-1:0] bsig0(input logic [WORD-1:0] x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic logic [WORD-1:0] bsig1(input logic [WORD-1:0] x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic logic [WORD-1:0] ssig0(input logic [WORD-1:0] x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [WORD-1:0] ssig1(input logic [WORD-1:0] x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic logic [WORD-1:0] choose(input logic [WORD-1:0] e, f, g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic logic [WORD-1:0] major(input logic [WORD-1:0] a, b, c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction

  // word i of the 16-word schedule window, word 0 the oldest
  function automatic logic [WORD-1:0] win_word(input logic [BLK_W-1:0] w, input int i);
    return w[BLK_W-1 - WORD*i -: WORD];
  endfunction

  // second message block of the header: bytes 64..79 plus padding for 640 bits
  function automatic logic [BLK_W-1:0] tail_block(input logic [TAIL_W-1:0] tail,
                                                  input logic [WORD-1:0] n);
    return {tail, n[7:0], n[15:8], n[23:16], n[31:24], 8'h80, 312'd0, 64'd640};
  endfunction

  // single padded block holding a 32-byte digest
  function automatic logic [BLK_W-1:0] digest_block(input logic [DIG_W-1:0] d);
    return {d, 8'h80, 184'd0, 64'd256};
  endfunction

  // compact word from header bytes 72..75 (little-endian), tail holds bytes 64..75
  function automatic logic [WORD-1:0] compact_of(input logic [TAIL_W-1:0] tail);
    return {tail[7:0], tail[15:8], tail[23:16], tail[31:24]};
  endfunction

  function automatic logic [DIG_W-1:0] expand_target(input logic [WORD-1:0] bits);
    logic [DIG_W-1:0] m;
    int ex;
    ex = int'(bits[31:24]);
    m  = {232'd0, bits[23:0]};
    if (ex >= 3) return m << (8 * (ex - 3));
    else         return m >> (8 * (3 - ex));
  endfunction

  function automatic logic [DIG_W-1:0] byte_rev(input logic [DIG_W-1:0] d);
    logic [DIG_W-1:0] r;
    for (int i = 0; i < DIG_W/8; i++) r[8*i +: 8] = d[DIG_W-1 - 8*i -: 8];
    return r;
  endfunction
endpackage

// File: rtl/ns_sha_core.sv
module ns_sha_core
  import ns_pkg::*;
#(
  parameter int ROUNDS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [DIG_W-1:0] iv,
  input  logic [BLK_W-1:0] blk,
  output logic             busy,
  output logic             done,
  output logic [DIG_W-1:0] digest
);
  localparam int CW = $clog2(ROUNDS);
  localparam int NW = DIG_W / WORD;
  localparam logic [CW-1:0] LAST_RND = CW'(ROUNDS - 1);

  logic [DIG_W-1:0] st_q, iv_q;
  logic [BLK_W-1:0] w_q;
  logic [CW-1:0]    rnd_q;
  logic [WORD-1:0]  va, vb, vc, vd, ve, vf, vg, vh, t1, t2, wt, wnew;

  always_comb begin
    {va, vb, vc, vd, ve, vf, vg, vh} = st_q;
    wt   = win_word(w_q, 0);
    t1   = vh + bsig1(ve) + choose(ve, vf, vg) + round_k(6'(rnd_q)) + wt;
    t2   = bsig0(va) + major(va, vb, vc);
    wnew = ssig1(win_word(w_q, 14)) + win_word(w_q, 9) + ssig0(win_word(w_q, 1)) + wt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      iv_q  <= '0;
      w_q   <= '0;
      rnd_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else if (start) begin
      st_q  <= iv;
      iv_q  <= iv;
      w_q   <= blk;
      rnd_q <= '0;
      busy  <= 1'b1;
      done  <= 1'b0;
    end else if (abort) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        st_q  <= {t1 + t2, va, vb, vc, vd + t1, ve, vf, vg};
        w_q   <= {w_q[BLK_W-WORD-1:0], wnew};
        rnd_q <= rnd_q + CW'(1);
        if (rnd_q == LAST_RND) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < NW; i++) begin : g_fold
    assign digest[WORD*i +: WORD] = iv_q[WORD*i +: WORD] + st_q[WORD*i +: WORD];
  end
endmodule

// File: rtl/ns_target_cmp.sv
module ns_target_cmp
  import ns_pkg::*;
(
  input  logic [WORD-1:0]  compact,
  input  logic [DIG_W-1:0] digest,
  output logic             hit
);
  logic [DIG_W-1:0] target, value;

  always_comb begin
    target = expand_target(compact);
    value  = byte_rev(digest);
    hit    = value < target;
  end
endmodule

// File: rtl/nonce_search.sv
module nonce_search
  import ns_pkg::*;
#(
  parameter int NONCE_BITS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               start,
  input  logic [HDR_W-1:0]   header,
  output logic               found,
  output logic               done,
  output logic [WORD-1:0]    nonce
);
  localparam logic [NONCE_BITS-1:0] LAST = '1;
  localparam logic [NONCE_BITS-1:0] ONE  = NONCE_BITS'(1);

  ns_state_e               st_q;
  logic [TAIL_W-1:0]       tail_q;
  logic [DIG_W-1:0]        mid_q;
  logic [NONCE_BITS-1:0]   n1_q, n2_q, win_q, nxt_n;

  logic             c1_start, c1_abort, c1_busy, c1_done;
  logic [DIG_W-1:0] c1_iv, c1_digest;
  logic [BLK_W-1:0] c1_blk;
  logic             c2_start, c2_abort, c2_busy, c2_done;
  logic [DIG_W-1:0] c2_digest;
  logic             hit;

  // named events used by the control logic and the checker
  logic start_go, launch_first, handoff, relaunch, hit_evt, last_evt;

  always_comb begin
    start_go     = start & ~clr;
    launch_first = (st_q == S_MID) & c1_done & ~clr & ~start;
    handoff      = (st_q == S_SRCH) & c1_done;
    hit_evt      = (st_q == S_SRCH) & c2_done & hit;
    last_evt     = (st_q == S_SRCH) & c2_done & ~hit & (n2_q == LAST);
    relaunch     = handoff & ~hit_evt & (n1_q != LAST) & ~clr & ~start;
    nxt_n        = launch_first ? '0 : n1_q + ONE;

    c1_start = start_go | launch_first | relaunch;
    c1_abort = clr | hit_evt;
    c1_iv    = start_go ? SHA_IV : ((st_q == S_MID) ? c1_digest : mid_q);
    c1_blk   = start_go ? header[HDR_W-1 -: BLK_W] : tail_block(tail_q, WORD'(nxt_n));

    c2_start = handoff & ~hit_evt & ~clr & ~start;
    c2_abort = clr | start;
  end

  ns_sha_core u_pass1 (
    .clk(clk), .rst_n(rst_n), .start(c1_start), .abort(c1_abort),
    .iv(c1_iv), .blk(c1_blk), .busy(c1_busy), .done(c1_done), .digest(c1_digest)
  );

  ns_sha_core u_pass2 (
    .clk(clk), .rst_n(rst_n), .start(c2_start), .abort(c2_abort),
    .iv(SHA_IV), .blk(digest_block(c1_digest)), .busy(c2_busy), .done(c2_done),
    .digest(c2_digest)
  );

  ns_target_cmp u_cmp (
    .compact(compact_of(tail_q)), .digest(c2_digest), .hit(hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      tail_q <= '0;
      mid_q  <= '0;
      n1_q   <= '0;
      n2_q   <= '0;
      win_q  <= '0;
      found  <= 1'b0;
      done   <= 1'b0;
    end else if (clr) begin
      st_q  <= S_IDLE;
      win_q <= '0;
      found <= 1'b0;
      done  <= 1'b0;
    end else if (start) begin
      st_q   <= S_MID;
      tail_q <= header[HDR_W-BLK_W-1 -: TAIL_W];
      win_q  <= '0;
      found  <= 1'b0;
      done   <= 1'b0;
    end else begin
      unique case (st_q)
        S_MID: if (c1_done) begin
          mid_q <= c1_digest;
          n1_q  <= '0;
          st_q  <= S_SRCH;
        end
        S_SRCH: begin
          if (handoff) begin
            n2_q <= n1_q;
            if (relaunch) n1_q <= n1_q + ONE;
          end
          if (hit_evt) begin
            win_q <= n2_q;
            found <= 1'b1;
            done  <= 1'b1;
            st_q  <= S_FIN;
          end else if (last_evt) begin
            done <= 1'b1;
            st_q <= S_FIN;
          end
        end
        default: ;
      endcase
    end
  end

  assign nonce = WORD'(win_q);
endmodule

// File: rtl/nonce_search_chk.sv
module nonce_search_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic        start,
  input logic        found,
  input logic        done,
  input logic [31:0] nonce,
  input logic        handoff,
  input logic        c1_busy,
  input logic        c2_busy,
  input logic        c2_done
);
  assert_zero_nonce_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> nonce == 32'd0) else $error("nonce nonzero without found");

  assert_found_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> done) else $error("found without done");

  assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (found && !clr && !start) |=> (found && $stable(nonce))) else $error("result not held");

  assert_start_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !found)) else $error("start did not release outcome");

  assert_clear_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!done && !found)) else $error("clear did not flush");

  assert_done_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(c2_done)) else $error("done without second-stage completion");

  assert_stage_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    handoff |-> !c2_busy) else $error("second stage busy at handoff");

  assert_idle_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!c1_busy && !c2_busy)) else $error("stage still running after done");
endmodule

bind nonce_search nonce_search_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .found(found), .done(done),
  .nonce(nonce), .handoff(handoff), .c1_busy(c1_busy), .c2_busy(c2_busy), .c2_done(c2_done)
);

// File: tb/nonce_search_test.sv
`timescale 1ns/1ps
module nonce_search_test;
  localparam int NB    = 6;
  localparam int NCAND = 1 << NB;
  localparam int FIRST_CYC = 195;
  localparam int STEP_CYC  = 65;

  localparam logic [31:0] KT [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  localparam logic [255:0] H0 = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                 32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  // stimulus table: {compact word, header seed}
  localparam logic [63:0] VEC [6] = '{
    {32'h207fffff, 32'h00000001},
    {32'h203fffff, 32'h13572468},
    {32'h20100000, 32'h0badcafe},
    {32'h2200ffff, 32'h55aa0f0f},
    {32'h02ffffff, 32'h76543210},
    {32'h1d000000, 32'h31415926}};

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, start = 1'b0;
  logic [639:0] header = '0;
  logic found, done;
  logic [31:0] nonce;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  nonce_search #(.NONCE_BITS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .header(header),
    .found(found), .done(done), .nonce(nonce));

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} >> n;
    return d[31:0];
  endfunction

  function automatic logic [255:0] compress(input logic [255:0] hin, input logic [511:0] m);
    logic [31:0] w [64];
    logic [31:0] s [8];
    logic [31:0] x1, x2, s0, s1;
    logic [255:0] hout;
    for (int t = 0; t < 16; t++) w[t] = m[511 - 32*t -: 32];
    for (int t = 16; t < 64; t++) begin
      s0 = rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3);
      s1 = rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10);
      w[t] = s1 + w[t-7] + s0 + w[t-16];
    end
    for (int i = 0; i < 8; i++) s[i] = hin[255 - 32*i -: 32];
    for (int t = 0; t < 64; t++) begin
      x1 = s[7] + (rr(s[4], 6) ^ rr(s[4], 11) ^ rr(s[4], 25)) +
           ((s[4] & s[5]) ^ (~s[4] & s[6])) + KT[t] + w[t];
      x2 = (rr(s[0], 2) ^ rr(s[0], 13) ^ rr(s[0], 22)) +
           ((s[0] & s[1]) ^ (s[0] & s[2]) ^ (s[1] & s[2]));
      for (int i = 7; i > 0; i--) s[i] = s[i-1];
      s[4] = s[4] + x1;
      s[0] = x1 + x2;
    end
    for (int i = 0; i < 8; i++) hout[255 - 32*i -: 32] = hin[255 - 32*i -: 32] + s[i];
    return hout;
  endfunction

  // double hash of the header with candidate n, result as little-endian integer
  function automatic logic [255:0] dsha_value(input logic [639:0] h, input logic [31:0] n);
    logic [7:0] mb [128];
    logic [1023:0] msg;
    logic [511:0] b2;
    logic [255:0] d1, d2, v;
    for (int j = 0; j < 128; j++) mb[j] = 8'h00;
    for (int j = 0; j < 80; j++) mb[j] = h[639 - 8*j -: 8];
    for (int j = 0; j < 4; j++) mb[76 + j] = n[8*j +: 8];
    mb[80] = 8'h80;
    mb[126] = 8'h02;
    mb[127] = 8'h80;
    for (int j = 0; j < 128; j++) msg[1023 - 8*j -: 8] = mb[j];
    d1 = compress(compress(H0, msg[1023:512]), msg[511:0]);
    b2 = '0;
    b2[511:256] = d1;
    b2[255:248] = 8'h80;
    b2[15:8] = 8'h01;
    d2 = compress(H0, b2);
    for (int j = 0; j < 32; j++) v[8*j +: 8] = d2[255 - 8*j -: 8];
    return v;
  endfunction

  function automatic logic [255:0] target_of(input logic [31:0] bits);
    logic [255:0] t;
    int pos;
    t = '0;
    for (int i = 0; i < 3; i++) begin
      pos = int'(bits[31:24]) - 3 + i;
      if (pos >= 0 && pos < 32) t[8*pos +: 8] = bits[8*i +: 8];
    end
    return t;
  endfunction

  function automatic logic [639:0] mk_hdr(input logic [31:0] seed, input logic [31:0] bits,
                                          input logic [31:0] junk);
    logic [639:0] h;
    logic [7:0] b;
    for (int j = 0; j < 80; j++) begin
      b = seed[8*(j % 4) +: 8] ^ 8'((j * 29 + 11) & 255);
      h[639 - 8*j -: 8] = b;
    end
    for (int j = 0; j < 4; j++) begin
      h[639 - 8*(72 + j) -: 8] = bits[8*j +: 8];
      h[639 - 8*(76 + j) -: 8] = junk[8*j +: 8];
    end
    return h;
  endfunction

  task automatic model(input logic [639:0] h, output bit ef, output int ek);
    logic [255:0] tgt;
    logic [31:0] bits;
    bits = {h[39:32], h[47:40], h[55:48], h[63:56]};
    tgt = target_of(bits);
    ef = 1'b0;
    ek = NCAND - 1;
    for (int k = 0; k < NCAND; k++) begin
      if (!ef && dsha_value(h, 32'(k)) < tgt) begin
        ef = 1'b1;
        ek = k;
      end
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [639:0] h);
    @(negedge clk);
    header = h;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 8000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic run_check(input logic [639:0] h, input logic [639:0] h_late, input string tag);
    bit ef;
    int ek, cyc, ecyc;
    model(h, ef, ek);
    ecyc = FIRST_CYC + STEP_CYC * ek;
    launch(h);
    header = h_late;
    wait_done(cyc);
    chk(cyc == ecyc, tag, "cycles start->done (R9)", cyc, ecyc);
    chk(found == ef, tag, ef ? "found (R4)" : "found low on exhaustion (R7)", found, ef);
    chk(nonce == (ef ? 32'(ek) : 32'd0), tag, "nonce lowest hit (R2 R3 R5)", nonce, ef ? ek : 0);
  endtask

  initial begin
    #(8 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [639:0] h, h2;
    logic [31:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(found == 1'b0, "R1", "found after reset", found, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(nonce == 32'd0, "R1", "nonce after reset", nonce, 0);

    // table walk: R2 R3 R4 R5 R7 R9
    for (int v = 0; v < 6; v++) begin
      h = mk_hdr(VEC[v][31:0], VEC[v][63:32], 32'hdead0000 + 32'(v));
      run_check(h, h, (v >= 4) ? "R7" : "R4");
    end

    // R6: result held while header input changes and time passes
    h = mk_hdr(VEC[0][31:0], VEC[0][63:32], 32'h0);
    run_check(h, h, "R6");
    keep = nonce;
    header = mk_hdr(32'h99999999, 32'h1d000000, 32'h1);
    repeat (300) @(negedge clk);
    chk(found == 1'b1 && done == 1'b1, "R6", "outcome held", {found, done}, 2'b11);
    chk(nonce == keep, "R6", "nonce held", nonce, keep);
    // R6: start releases the outcome
    launch(h);
    chk(done == 1'b0 && found == 1'b0, "R6", "start releases outcome", {found, done}, 0);

    // R8: clear in mid-search flushes both stages
    launch(h);
    repeat (150) @(negedge clk);
    clr = 1'b1;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clr = 1'b0;
    start = 1'b0;
    chk(done == 1'b0 && found == 1'b0, "R8", "flags after clear", {found, done}, 0);
    repeat (400) @(negedge clk);
    chk(done == 1'b0 && found == 1'b0 && nonce == 32'd0, "R8", "no stale result", {found, done}, 0);

    // R10: header changed right after start has no effect
    h  = mk_hdr(VEC[1][31:0], VEC[1][63:32], 32'h77);
    h2 = mk_hdr(32'h24681357, 32'h2200ffff, 32'h88);
    run_check(h, h2, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule